// File: doc/BRIEF.md
# SPI Transfer Pause Gate

This block sits between the raw serial pins of an SPI target and the command engine behind it. It brings chip select, serial clock, serial data in and an active-low pause request into the system clock domain, then turns the serial clock into single-cycle rising and falling edge strobes for the engine. The data-in bit is presented with each rising strobe. The pause request lets a host freeze a transfer partway through. While the transfer is frozen, clock and data activity on the pins is swallowed. Once the pause is released, the engine picks up at the bit it had reached, because it never saw the swallowed edges.

The pause starts and ends only at points that are legal relative to the serial clock. A pause request raised while the clock is low takes effect at once. A request raised while the clock is high waits for the next falling edge, and that edge is still delivered. Release is accepted only when the request is withdrawn while the clock is low. The serial output pad is driven from the engine's data and enable. It is released to high impedance whenever the pause request is low, whether or not the pause has taken effect yet. Deselecting the chip during a pause clears the pause and pulses an abort strobe to the engine.

Top module: `spi_hold_gate`

## Requirements
- R1: While selected (`cs_n_pin` low) and not paused, each rising SCK edge gives exactly one `sck_rise_stb` pulse and each falling edge exactly one `sck_fall_stb` pulse. While deselected, no strobe is produced.
- R2: `si_bit` shows the SI level sampled at the most recent delivered rising strobe and changes at no other time. Bits reach the engine in the order the host sends them.
- R3: When `hold_n_pin` is low while SCK is low and the chip is selected, the pause begins. After that, SCK and SI activity produce no strobe and leave `si_bit` unchanged.
- R4: When `hold_n_pin` falls while SCK is high, the next falling SCK edge is still delivered as a strobe. The pause begins right after that edge.
- R5: A pause ends when `hold_n_pin` rises while SCK is low. Strobes then resume, and the bits sent after the pause complete the byte begun before it.
- R6: A rise of `hold_n_pin` while SCK is high does not end the pause. The pause persists until the pause request is lowered and raised again while SCK is low.
- R7: `so_pad_oe` (1 = drive, 0 = high impedance) is 0 whenever `hold_n_pin` is low, the chip is deselected or the block is paused. Otherwise it follows `eng_so_oe`, and `so_pad` follows `eng_so`.
- R8: Raising `cs_n_pin` during a pause clears the pause and gives one `eng_abort` pulse. Raising it when not paused gives no pulse. After reselection, strobes flow again.
- R9: `sck_rise_stb` and `sck_fall_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| si_pin | input | 1 | Serial data in pin |
| hold_n_pin | input | 1 | Pause request pin, active low |
| eng_so | input | 1 | Serial output bit from the engine |
| eng_so_oe | input | 1 | Output enable request from the engine |
| sck_rise_stb | output | 1 | One-cycle strobe per delivered rising SCK edge |
| sck_fall_stb | output | 1 | One-cycle strobe per delivered falling SCK edge |
| si_bit | output | 1 | SI level captured at the last delivered rising edge |
| eng_abort | output | 1 | One-cycle pulse when deselected during a pause |
| so_pad | output | 1 | Serial output pad value |
| so_pad_oe | output | 1 | Serial output pad drive enable |

## Verification
On every cycle, the assertions check several properties. Both strobes never appear together. No strobe leaves the block in the cycle after the paused state. The pause begins only when clock and request are both low, and it ends only on deselect or when the request is high with the clock low. The pad enable drops after the request goes low or the chip is deselected, and the abort pulse follows only a paused state. Other behaviour only the directed scenarios can show. These cover deferral of entry to the next falling edge, rejection of a release made while the clock is high, and intact bytes across a pause. They also check that SI toggling during a pause leaves `si_bit` alone.

// File: rtl/spg_pkg.sv
package spg_pkg;

    // Synchronised view of the serial pins.
    typedef struct packed {
        logic cs_n;
        logic sck;
        logic si;
        logic hold_n;
    } pin_vec_t;

    localparam int PIN_W = $bits(pin_vec_t);

    // Reset level of the pins: deselected, clock low, no pause request.
    localparam logic [PIN_W-1:0] PIN_IDLE = {1'b1, 1'b0, 1'b0, 1'b1};

    // Registered state of the gating engine.
    typedef struct packed {
        logic paused;
        logic sck_prev;
        logic hold_prev;
        logic rise;
        logic fall;
        logic si;
        logic abort;
    } gate_state_t;

    // Registered state of the output pad stage.
    typedef struct packed {
        logic oe;
        logic dat;
    } pad_state_t;

endpackage

// File: rtl/spg_sync.sv
module spg_sync #(
    parameter int              WIDTH     = 4,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : gen_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RESET_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[LAST];

    initial begin
        AST_SYNC_DEPTH: assert (STAGES >= 2); // R1
    end
endmodule

// File: rtl/spg_pause_fsm.sv
module spg_pause_fsm
    import spg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_vec_t pins,
    output logic     rise_stb,
    output logic     fall_stb,
    output logic     si_bit,
    output logic     abort_stb,
    output logic     paused
);
    gate_state_t st_d, st_q;

    logic sck_up;
    logic sck_down;
    logic hold_up;
    logic deliver;

    always_comb begin
        sck_up   = pins.sck && !st_q.sck_prev;
        sck_down = !pins.sck && st_q.sck_prev;
        hold_up  = pins.hold_n && !st_q.hold_prev;
        deliver  = !st_q.paused && !pins.cs_n;

        st_d           = st_q;
        st_d.sck_prev  = pins.sck;
        st_d.hold_prev = pins.hold_n;
        st_d.rise      = sck_up && deliver;
        st_d.fall      = sck_down && deliver;
        st_d.abort     = st_q.paused && pins.cs_n;

        if (sck_up && deliver) begin
            st_d.si = pins.si;
        end

        // Pause transitions use the same synchronised clock level as edges.
        if (pins.cs_n) begin
            st_d.paused = 1'b0;
        end else if (!st_q.paused) begin
            if (!pins.hold_n && !pins.sck) st_d.paused = 1'b1;
        end else begin
            if (hold_up && !pins.sck) st_d.paused = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{paused: 1'b0, sck_prev: 1'b0, hold_prev: 1'b1,
                      rise: 1'b0, fall: 1'b0, si: 1'b0, abort: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_stb  = st_q.rise;
    assign fall_stb  = st_q.fall;
    assign si_bit    = st_q.si;
    assign abort_stb = st_q.abort;
    assign paused    = st_q.paused;

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.rise && st_q.fall)); // R9
    AST_NO_STB_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.paused |=> !(st_q.rise || st_q.fall)); // R3
    AST_ENTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.paused) |-> $past(!pins.sck && !pins.hold_n && !pins.cs_n)); // R4
    AST_EXIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.paused) |-> $past(pins.cs_n || (!pins.sck && pins.hold_n))); // R5
    AST_CS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pins.cs_n |=> !st_q.paused); // R8
    AST_ABORT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.abort |-> $past(st_q.paused)); // R8
endmodule

// File: rtl/spg_so_gate.sv
module spg_so_gate
    import spg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_vec_t pins,
    input  logic     paused,
    input  logic     eng_so,
    input  logic     eng_so_oe,
    output logic     so_pad,
    output logic     so_pad_oe
);
    pad_state_t pad_d, pad_q;

    always_comb begin
        pad_d     = pad_q;
        pad_d.dat = eng_so;
        // A low pause request releases the pad at once, before qualification.
        pad_d.oe  = eng_so_oe && !pins.cs_n && pins.hold_n && !paused;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pad_q <= '{oe: 1'b0, dat: 1'b0};
        else        pad_q <= pad_d;
    end

    assign so_pad    = pad_q.dat;
    assign so_pad_oe = pad_q.oe;

    AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pins.hold_n |=> !pad_q.oe); // R7
    AST_OE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        pins.cs_n |=> !pad_q.oe); // R7
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
    import spg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic si_pin,
    input  logic hold_n_pin,
    input  logic eng_so,
    input  logic eng_so_oe,
    output logic sck_rise_stb,
    output logic sck_fall_stb,
    output logic si_bit,
    output logic eng_abort,
    output logic so_pad,
    output logic so_pad_oe
);
    pin_vec_t           raw_pins;
    logic [PIN_W-1:0]   sync_bits;
    pin_vec_t           sync_pins;
    logic               paused;

    assign raw_pins = '{cs_n: cs_n_pin, sck: sck_pin, si: si_pin, hold_n: hold_n_pin};

    spg_sync #(
        .WIDTH     (PIN_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_pins),
        .dout  (sync_bits)
    );

    assign sync_pins = pin_vec_t'(sync_bits);

    spg_pause_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (sync_pins),
        .rise_stb  (sck_rise_stb),
        .fall_stb  (sck_fall_stb),
        .si_bit    (si_bit),
        .abort_stb (eng_abort),
        .paused    (paused)
    );

    spg_so_gate u_so (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (sync_pins),
        .paused    (paused),
        .eng_so    (eng_so),
        .eng_so_oe (eng_so_oe),
        .so_pad    (so_pad),
        .so_pad_oe (so_pad_oe)
    );

    AST_ABORT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> !eng_abort); // R8
endmodule

// File: tb/spi_hold_gate_bench.sv
module spi_hold_gate_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n_pin = 1'b1, sck_pin = 1'b0, si_pin = 1'b0, hold_n_pin = 1'b1;
    logic eng_so = 1'b1, eng_so_oe = 1'b1;
    logic sck_rise_stb, sck_fall_stb, si_bit, eng_abort, so_pad, so_pad_oe;

    int checks = 0, fails = 0;
    int rcnt = 0, fcnt = 0, acnt = 0, both_cnt = 0;
    logic [7:0] shreg = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_hold_gate u_spi_hold_gate (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
        .si_pin(si_pin), .hold_n_pin(hold_n_pin), .eng_so(eng_so),
        .eng_so_oe(eng_so_oe), .sck_rise_stb(sck_rise_stb),
        .sck_fall_stb(sck_fall_stb), .si_bit(si_bit), .eng_abort(eng_abort),
        .so_pad(so_pad), .so_pad_oe(so_pad_oe)
    );

    always @(posedge clk) begin
        if (sck_rise_stb) begin
            rcnt++;
            shreg <= {shreg[6:0], si_bit};
        end
        if (sck_fall_stb) fcnt++;
        if (eng_abort) acnt++;
        if (sck_rise_stb && sck_fall_stb) both_cnt++;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sck_pulse();
        sck_pin = 1'b1; wait_clk(6);
        sck_pin = 1'b0; wait_clk(6);
    endtask

    task automatic send_bit(input logic b);
        si_pin = b; wait_clk(2);
        sck_pulse();
    endtask

    task automatic clear_counts();
        rcnt = 0; fcnt = 0; shreg = '0;
    endtask

    task automatic t_reset();
        check(sck_rise_stb == 0 && sck_fall_stb == 0, "R1 reset strobes", sck_rise_stb, 0);
        check(so_pad_oe == 0, "R7 reset oe", so_pad_oe, 0);
        check(eng_abort == 0 && si_bit == 0, "R2 reset si/abort", si_bit, 0);
    endtask

    task automatic t_normal();
        logic [7:0] b = 8'hA5;
        cs_n_pin = 1'b0; wait_clk(6); clear_counts();
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        check(rcnt == 8, "R1 rise count", rcnt, 8);
        check(fcnt == 8, "R1 fall count", fcnt, 8);
        check(shreg == 8'hA5, "R2 byte", shreg, 8'hA5);
        cs_n_pin = 1'b1; wait_clk(6); clear_counts();
        sck_pulse(); sck_pulse();
        check(rcnt == 0 && fcnt == 0, "R1 deselected", rcnt + fcnt, 0);
        check(so_pad_oe == 0, "R7 deselected oe", so_pad_oe, 0);
    endtask

    task automatic t_pause_low();
        logic [7:0] b = 8'hC3;
        cs_n_pin = 1'b0; wait_clk(6); clear_counts();
        check(so_pad_oe == 1, "R7 oe active", so_pad_oe, 1);
        for (int i = 7; i >= 5; i--) send_bit(b[i]);
        hold_n_pin = 1'b0; wait_clk(6);
        check(so_pad_oe == 0, "R7 oe during pause", so_pad_oe, 0);
        for (int k = 0; k < 3; k++) send_bit(k[0]);
        check(rcnt == 3 && fcnt == 3, "R3 strobes blocked", rcnt, 3);
        check(shreg[2:0] == 3'b110 && si_bit == 1'b0, "R3 si held", shreg[2:0], 6);
        hold_n_pin = 1'b1; wait_clk(6);
        for (int i = 4; i >= 0; i--) send_bit(b[i]);
        check(rcnt == 8 && shreg == 8'hC3, "R5 byte across pause", shreg, 8'hC3);
    endtask

    task automatic t_pause_high();
        clear_counts();
        send_bit(1'b1); send_bit(1'b0);
        si_pin = 1'b1; wait_clk(2);
        sck_pin = 1'b1; wait_clk(6);
        hold_n_pin = 1'b0; wait_clk(6);
        check(so_pad_oe == 0, "R7 oe drops with clock high", so_pad_oe, 0);
        check(fcnt == 2, "R4 no early fall", fcnt, 2);
        sck_pin = 1'b0; wait_clk(6);
        check(fcnt == 3, "R4 deferred fall delivered", fcnt, 3);
        sck_pulse(); sck_pulse();
        check(rcnt == 3 && fcnt == 3, "R4 paused after fall", rcnt, 3);
        hold_n_pin = 1'b1; wait_clk(6);
        send_bit(1'b0);
        check(rcnt == 4, "R5 resume", rcnt, 4);
    endtask

    task automatic t_release_high();
        int r0;
        hold_n_pin = 1'b0; wait_clk(6);
        r0 = rcnt;
        sck_pin = 1'b1; wait_clk(6);
        hold_n_pin = 1'b1; wait_clk(6);
        sck_pin = 1'b0; wait_clk(6);
        sck_pulse();
        check(rcnt == r0, "R6 release with clock high", rcnt, r0);
        hold_n_pin = 1'b0; wait_clk(4);
        hold_n_pin = 1'b1; wait_clk(6);
        sck_pulse();
        check(rcnt == r0 + 1, "R6 release with clock low", rcnt, r0 + 1);
    endtask

    task automatic t_deselect();
        int r0;
        check(acnt == 0, "R8 no abort when not paused", acnt, 0);
        hold_n_pin = 1'b0; wait_clk(6);
        cs_n_pin = 1'b1; wait_clk(6);
        check(acnt == 1, "R8 abort pulse", acnt, 1);
        hold_n_pin = 1'b1; cs_n_pin = 1'b0; wait_clk(6);
        r0 = rcnt;
        sck_pulse();
        check(rcnt == r0 + 1, "R8 strobes after reselect", rcnt, r0 + 1);
    endtask

    task automatic t_so_path();
        eng_so = 1'b0; wait_clk(3);
        check(so_pad_oe == 1 && so_pad == 0, "R7 so low", so_pad, 0);
        eng_so = 1'b1; wait_clk(3);
        check(so_pad == 1, "R7 so high", so_pad, 1);
        eng_so_oe = 1'b0; wait_clk(3);
        check(so_pad_oe == 0, "R7 engine disable", so_pad_oe, 0);
        check(both_cnt == 0, "R9 strobes exclusive", both_cnt, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_normal();
        t_pause_low();
        t_pause_high();
        t_release_high();
        t_deselect();
        t_so_path();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule